// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

The block supervises software by counting clock cycles from the last accepted service. If software lets the programmed period run out, the block raises a one-cycle system reset request. Service is accepted only when a fixed key byte is written to a dedicated write-only location. Writing the wrong byte forces an immediate reset request.

An optional window mode places a closed interval in front of the open interval. A service attempt during the closed interval is treated as a fault. An early-warning flag with its own interrupt enable is raised at a programmable count, which gives software a chance to react before the timeout. An always-on lock forces the timer to keep running and freezes control and configuration until the next system reset.

The block is programmed through a byte-wide register port. Software learns that a write is still settling from a busy bit, which stays high for a fixed number of cycles after every write.

Top module: `win_watchdog`

## Requirements
- R1: After reset the registers read as follows: control (0x0) reads 0x00, configuration (0x1) reads 0xBB and warning control (0x2) reads 0x0B. Status (0x7), flag (0x6) and service (0x8) all read 0x00, and `irq_warn` and `rst_req` are low. Reserved bits always read zero: control bits 0 and 6:3, and warning-control bits 7:4.
- R2: All lengths use one encoding: a 4-bit code n selects 8·2^n cycles, and codes above 11 act as 11. The period code is in configuration bits 3:0. With window mode off, `rst_req` is high for exactly one cycle, N cycles after the write that enabled the timer or after the last accepted service, where N is the period length. The count then restarts from zero.
- R3: Writing 0xA5 to offset 0x8 while the timer runs and is outside the closed interval restarts the count without a reset request.
- R4: Writing any other byte to 0x8 while the timer runs raises `rst_req` for one cycle, in the cycle after the write, and restarts the count.
- R5: Window mode is enabled by control bit 2. In this mode the closed-interval code (configuration bits 7:4) gives W cycles. A service written at or before W cycles after the restart is a fault, and it behaves as in R4. A service written later is accepted. Without service, the timeout comes W+P cycles after the restart, where P is the period length.
- R6: The warning flag (bit 0 of 0x6) sets when the count since the restart reaches the length given by warning-control bits 3:0. It stays set until software writes 1 to that bit. Writing 0 to the bit has no effect.
- R7: Writing 1 to bit 0 of 0x5 sets the interrupt enable, and writing 1 to bit 0 of 0x4 clears it. Writing 0 to either register has no effect. Both offsets read the enable in bit 0, and `irq_warn` equals the flag AND the enable.
- R8: Writing control with bit 7 set locks the block. Control then reads with bits 7 and 1 set, the timer runs, and later writes to control and configuration are ignored until reset.
- R9: After any register write, status bit 7 reads 1 for the 3 cycles that follow and then returns to 0.
- R10: While control bit 1 is clear and the block is not locked, the count stays at zero. In this state no reset request and no warning occur, and writes to 0x8 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 4 | Register byte offset for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| irq_warn | output | 1 | Early-warning interrupt |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench attacks the boundary of the closed interval. It services exactly one cycle after the interval ends, which must be accepted, and exactly on its last cycle, which must be a fault. A design whose comparison is off by one would let the wrong one of these two through. Each reset pulse is matched by a scoreboard to the edge predicted from the write that started the count. A counter that reloads late or early, or that ignores the closed interval when it computes the timeout, shows up as a timing mismatch. Writes of zero to the flag and enable registers, wrong keys while the timer is disabled, and writes after the lock must all leave the read-back values and the outputs untouched. The bench also checks that a period code above 11 is clamped to the longest period.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned CODE_MAX = 11;
  localparam int unsigned BASE_LEN = 8;
  // enough bits for closed interval plus period, both at their maximum
  localparam int unsigned CNT_W    = $clog2(2 * (BASE_LEN << CODE_MAX)) + 1;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_CFG   = 4'h1;
  localparam logic [ADDR_W-1:0] OFS_WARN  = 4'h2;
  localparam logic [ADDR_W-1:0] OFS_IEOFF = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_IEON  = 4'h5;
  localparam logic [ADDR_W-1:0] OFS_FLAG  = 4'h6;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 4'h7;
  localparam logic [ADDR_W-1:0] OFS_SVC   = 4'h8;

  typedef logic [CNT_W-1:0] cnt_t;

  // code n selects BASE_LEN * 2^n cycles, codes past CODE_MAX saturate
  function automatic cnt_t code_len(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] c;
    c = (code > CODE_W'(CODE_MAX)) ? CODE_W'(CODE_MAX) : code;
    return cnt_t'(BASE_LEN) << c;
  endfunction
endpackage

// File: rtl/wwdt_regs.sv
module wwdt_regs
  import wwdt_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              flag,
  output logic              run,
  output logic              win_en,
  output logic              lock,
  output logic [CODE_W-1:0] per_code,
  output logic [CODE_W-1:0] win_code,
  output logic [CODE_W-1:0] warn_code,
  output logic              ie,
  output logic              flag_clr,
  output logic              svc_wr,
  output logic              busy,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned BUSY_W = $clog2(BUSY_CYCLES + 1);

  logic              run_q, run_d;
  logic              win_q, win_d;
  logic              lock_q, lock_d;
  logic [DATA_W-1:0] cfg_q, cfg_d;
  logic [CODE_W-1:0] warn_q, warn_d;
  logic              ie_q, ie_d;
  logic [BUSY_W-1:0] busy_q, busy_d;

  always_comb begin
    run_d  = run_q;
    win_d  = win_q;
    lock_d = lock_q;
    cfg_d  = cfg_q;
    warn_d = warn_q;
    ie_d   = ie_q;
    busy_d = (busy_q != '0) ? busy_q - 1'b1 : '0;
    if (wr_en) begin
      busy_d = BUSY_W'(BUSY_CYCLES);
      case (addr)
        OFS_CTRL: if (!lock_q) begin
          run_d  = wr_data[1] | wr_data[7];
          win_d  = wr_data[2];
          lock_d = wr_data[7];
        end
        OFS_CFG:   if (!lock_q) cfg_d = wr_data;
        OFS_WARN:  warn_d = wr_data[CODE_W-1:0];
        OFS_IEOFF: if (wr_data[0]) ie_d = 1'b0;
        OFS_IEON:  if (wr_data[0]) ie_d = 1'b1;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      win_q  <= 1'b0;
      lock_q <= 1'b0;
      cfg_q  <= 8'hBB;
      warn_q <= 4'hB;
      ie_q   <= 1'b0;
      busy_q <= '0;
    end else begin
      run_q  <= run_d;
      win_q  <= win_d;
      lock_q <= lock_d;
      cfg_q  <= cfg_d;
      warn_q <= warn_d;
      ie_q   <= ie_d;
      busy_q <= busy_d;
    end
  end

  assign run       = run_q;
  assign win_en    = win_q;
  assign lock      = lock_q;
  assign per_code  = cfg_q[3:0];
  assign win_code  = cfg_q[7:4];
  assign warn_code = warn_q;
  assign ie        = ie_q;
  assign busy      = (busy_q != '0);
  assign flag_clr  = wr_en && (addr == OFS_FLAG) && wr_data[0];
  assign svc_wr    = wr_en && (addr == OFS_SVC);

  always_comb begin
    case (addr)
      OFS_CTRL:            rd_data = {lock_q, 4'b0000, win_q, run_q, 1'b0};
      OFS_CFG:             rd_data = cfg_q;
      OFS_WARN:            rd_data = {{(DATA_W-CODE_W){1'b0}}, warn_q};
      OFS_IEOFF, OFS_IEON: rd_data = {{(DATA_W-1){1'b0}}, ie_q};
      OFS_FLAG:            rd_data = {{(DATA_W-1){1'b0}}, flag};
      OFS_STAT:            rd_data = {busy, {(DATA_W-1){1'b0}}};
      default:             rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wwdt_counter.sv
module wwdt_counter
  import wwdt_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              win_en,
  input  logic [CODE_W-1:0] per_code,
  input  logic [CODE_W-1:0] win_code,
  input  logic [CODE_W-1:0] warn_code,
  input  logic              svc_wr,
  input  logic [DATA_W-1:0] svc_data,
  output cnt_t              cnt,
  output logic              warn_hit,
  output logic              rst_req
);
  cnt_t cnt_q, cnt_d;
  cnt_t per_len, win_len, limit, warn_len;
  logic closed, svc_ok, svc_bad, expire;
  logic rst_q, rst_d;

  always_comb begin
    per_len  = code_len(per_code);
    win_len  = win_en ? code_len(win_code) : '0;
    limit    = per_len + win_len;
    warn_len = code_len(warn_code);
    closed   = win_en && (cnt_q < win_len);
    svc_ok   = run && svc_wr && (svc_data == KEY) && !closed;
    svc_bad  = run && svc_wr && !svc_ok;
    expire   = run && (cnt_q == limit - 1'b1);
    warn_hit = run && (cnt_q == warn_len - 1'b1);
    if (!run || svc_ok || svc_bad || expire) cnt_d = '0;
    else                                     cnt_d = cnt_q + 1'b1;
    rst_d = svc_bad | (expire & ~svc_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rst_q <= rst_d;
    end
  end

  assign cnt     = cnt_q;
  assign rst_req = rst_q;
endmodule

// File: rtl/wwdt_warn.sv
module wwdt_warn (
  input  logic clk,
  input  logic rst_n,
  input  logic warn_hit,
  input  logic flag_clr,
  input  logic ie,
  output logic flag,
  output logic irq
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (flag_clr) flag_d = 1'b0;
    if (warn_hit) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
  assign irq  = flag_q & ie;
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wwdt_pkg::*;
#(
  parameter logic [DATA_W-1:0] SERVICE_KEY = 8'hA5,
  parameter int unsigned       BUSY_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_warn,
  output logic              rst_req
);
  logic [1:0]        rst_sync;
  logic              rst_ni;
  logic              run, win_en, lock, ie, flag, flag_clr, svc_wr, busy, warn_hit;
  logic [CODE_W-1:0] per_code, win_code, warn_code;
  cnt_t              cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  wwdt_regs #(.BUSY_CYCLES(BUSY_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_ni), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .flag(flag), .run(run), .win_en(win_en), .lock(lock),
    .per_code(per_code), .win_code(win_code), .warn_code(warn_code),
    .ie(ie), .flag_clr(flag_clr), .svc_wr(svc_wr), .busy(busy), .rd_data(rd_data)
  );

  wwdt_counter #(.KEY(SERVICE_KEY)) u_cnt (
    .clk(clk), .rst_n(rst_ni), .run(run), .win_en(win_en),
    .per_code(per_code), .win_code(win_code), .warn_code(warn_code),
    .svc_wr(svc_wr), .svc_data(wr_data), .cnt(cnt), .warn_hit(warn_hit),
    .rst_req(rst_req)
  );

  wwdt_warn u_warn (
    .clk(clk), .rst_n(rst_ni), .warn_hit(warn_hit), .flag_clr(flag_clr),
    .ie(ie), .flag(flag), .irq(irq_warn)
  );
endmodule

// File: rtl/wwdt_checker.sv
module wwdt_checker
  import wwdt_pkg::*;
(
  input logic clk,
  input logic rst_ni,
  input logic wr_en,
  input logic run,
  input logic lock,
  input logic busy,
  input logic flag,
  input logic flag_clr,
  input logic warn_hit,
  input logic rst_req,
  input cnt_t cnt
);
  p_restart_after_req_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    rst_req |-> (cnt == '0));

  p_idle_no_request_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    !run |=> !rst_req);

  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    lock |=> (lock && run));

  p_flag_holds_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (flag && !flag_clr) |=> flag);

  p_flag_sets_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    warn_hit |=> flag);

  p_busy_follows_write_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en |=> busy);
endmodule

bind win_watchdog wwdt_checker u_chk (
  .clk(clk), .rst_ni(rst_ni), .wr_en(wr_en), .run(run), .lock(lock),
  .busy(busy), .flag(flag), .flag_clr(flag_clr), .warn_hit(warn_hit),
  .rst_req(rst_req), .cnt(cnt)
);

// File: tb/win_watchdog_tb.sv
module win_watchdog_tb;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [3:0] addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       irq_warn;
  logic       rst_req;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  int exp_q[$];

  win_watchdog u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq_warn(irq_warn), .rst_req(rst_req)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, output int e);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    e = cyc;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    check(req, int'(rd_data), int'(exp));
  endtask

  task automatic to_edge(input int n);
    while (cyc < n) begin
      @(posedge clk);
      #1;
    end
  endtask

  // monitor: every reset pulse must match the next predicted edge
  always @(negedge clk) begin
    int e;
    if (rst_n && mon_on && rst_req) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R2/R4 unexpected reset request: actual edge %0d expected none", cyc);
      end else begin
        e = exp_q.pop_front();
        check("R2/R4/R5 reset request edge", cyc, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int e, c, r;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mon_on = 1'b1;

    // R1 reset values
    rd_chk(4'h0, 8'h00, "R1 control");
    rd_chk(4'h1, 8'hBB, "R1 configuration");
    rd_chk(4'h2, 8'h0B, "R1 warning control");
    rd_chk(4'h7, 8'h00, "R1 status");
    rd_chk(4'h6, 8'h00, "R1 flag");
    rd_chk(4'h8, 8'h00, "R1 service reads zero");
    check("R1 irq low", int'(irq_warn), 0);
    check("R1 rst low", int'(rst_req), 0);

    // R1 reserved bits
    wr(4'h2, 8'hF3, e);
    rd_chk(4'h2, 8'h03, "R1 warning reserved bits");
    wr(4'h0, 8'h7D, e);
    rd_chk(4'h0, 8'h04, "R1 control reserved bits");
    wr(4'h0, 8'h00, e);

    // R9 busy window after a write
    wr(4'h2, 8'h00, e);
    rd_chk(4'h7, 8'h80, "R9 busy first cycle");
    to_edge(e + 2);
    rd_chk(4'h7, 8'h80, "R9 busy third cycle");
    to_edge(e + 3);
    rd_chk(4'h7, 8'h00, "R9 busy released");

    // R10 disabled: wrong key ignored, no warning
    wr(4'h1, 8'h11, e);
    wr(4'h8, 8'h00, e);
    to_edge(e + 40);
    rd_chk(4'h6, 8'h00, "R10 no warning while disabled");
    check("R10 no request while disabled", int'(rst_req), 0);

    // R2 timeout, R6 warning flag, R7 gating
    wr(4'h0, 8'h02, e);
    exp_q.push_back(e + 16);
    to_edge(e + 8);
    rd_chk(4'h6, 8'h01, "R6 flag set at warning length");
    check("R7 irq masked while enable off", int'(irq_warn), 0);
    wr(4'h5, 8'h01, c);
    @(negedge clk);
    check("R7 irq follows flag and enable", int'(irq_warn), 1);
    to_edge(e + 18);
    wr(4'h0, 8'h00, c);
    wr(4'h6, 8'h00, c);
    rd_chk(4'h6, 8'h01, "R6 writing zero keeps flag");
    wr(4'h6, 8'h01, c);
    rd_chk(4'h6, 8'h00, "R6 writing one clears flag");
    check("R7 irq drops with flag", int'(irq_warn), 0);

    // R7 enable set/clear registers
    wr(4'h5, 8'h00, c);
    rd_chk(4'h5, 8'h01, "R7 set register zero ignored");
    wr(4'h4, 8'h00, c);
    rd_chk(4'h4, 8'h01, "R7 clear register zero ignored");
    wr(4'h4, 8'h01, c);
    rd_chk(4'h5, 8'h00, "R7 clear register clears");

    // R3 keyed service keeps the timer alive
    wr(4'h0, 8'h02, r);
    for (int i = 0; i < 3; i++) begin
      to_edge(r + 9);
      wr(4'h8, 8'hA5, c);
      check("R3 service edge", c, r + 10);
      r = c;
    end
    exp_q.push_back(r + 16);
    to_edge(r + 20);
    wr(4'h0, 8'h00, c);
    check("R3 predicted reset consumed", exp_q.size(), 0);

    // R4 wrong key forces a request on the next cycle
    wr(4'h0, 8'h02, e);
    to_edge(e + 4);
    wr(4'h8, 8'h5A, c);
    exp_q.push_back(c);
    wr(4'h0, 8'h00, e);
    @(negedge clk);
    check("R4 request lasts one cycle", int'(rst_req), 0);
    check("R4 request seen", exp_q.size(), 0);

    // R5 window mode: closed 16, open 16
    wr(4'h0, 8'h06, e);
    to_edge(e + 16);
    wr(4'h8, 8'hA5, c);
    check("R5 first open-cycle service edge", c, e + 17);
    to_edge(c + 15);
    wr(4'h8, 8'hA5, r);
    exp_q.push_back(r);
    exp_q.push_back(r + 32);
    to_edge(r + 34);
    wr(4'h0, 8'h00, c);
    check("R5 closed fault and window timeout seen", exp_q.size(), 0);

    // R2 codes above eleven saturate at 16384 cycles
    wr(4'h1, 8'h0F, c);
    wr(4'h0, 8'h02, e);
    exp_q.push_back(e + 16384);
    to_edge(e + 16386);
    wr(4'h0, 8'h00, c);
    check("R2 saturated period seen", exp_q.size(), 0);

    // R8 always-on lock
    wr(4'h1, 8'h00, c);
    wr(4'h6, 8'h01, c);
    wr(4'h0, 8'h80, e);
    for (int k = 1; k <= 4; k++) exp_q.push_back(e + 8 * k);
    rd_chk(4'h0, 8'h82, "R8 lock forces enable");
    wr(4'h0, 8'h00, c);
    rd_chk(4'h0, 8'h82, "R8 control write ignored");
    wr(4'h1, 8'h55, c);
    rd_chk(4'h1, 8'h00, "R8 configuration write ignored");
    to_edge(e + 34);
    mon_on = 1'b0;
    check("R8 locked timer keeps expiring", exp_q.size(), 0);

    finish_run();
  end
endmodule